// File: doc/BRIEF.md
# MDIO Management Frame Register Master

This block lets software run one Clause 22 management transaction on an MDIO bus by writing a single 32-bit word. The word is laid out in the order its bits go on the wire: start pattern, opcode, PHY address, register address, turnaround, and sixteen data bits. After the write, the block sends a 32-bit run of ones, then shifts the word out MSB first on MDIO. It produces MDC from the system clock through a parameterised divider.

On a read, the block lets go of MDIO for the turnaround and data bits. It captures the PHY's sixteen data bits on rising MDC edges and places them in the low half of the same register. Software polls the register. The low turnaround bit, bit 16, reads back as 1 once the transaction has finished. A write that arrives while a transaction is running is dropped.

Top module: `mdio_frame_master`

## Requirements
- R1: After reset, the register reads 0x00010000, MDC is 0, the MDIO output enable is 0 and the MDIO output is 1.
- R2: MDC runs only during a transaction. Each bit time is HALF_DIV system clocks with MDC low, then HALF_DIV clocks with MDC high. Each transaction has exactly PRE_LEN+32 MDC pulses, and MDC is 0 while idle.
- R3: MDIO changes only when MDC falls, and holds steady across each rising edge. The bus carries PRE_LEN ones first, then the register word from bit 31 down to bit 0.
- R4: A write accepted while idle forces bit 16 to 0, whatever value was written. Bit 16 stays 0 for the whole transaction and becomes 1 exactly 2*HALF_DIV*(PRE_LEN+32) clocks after the accepting edge.
- R5: A write received while a transaction is in progress, including its final cycle, changes neither the register nor the bits sent.
- R6: When bits 29:28 equal 2'b10 (read), the output enable drops for the last 18 bit times, which are the turnaround and data bits. MDIO input is sampled on each of the last 16 rising MDC edges, MSB first, into bits 15:0.
- R7: For any other opcode value, the output enable stays high for every bit time. At completion, bits 15:0 still hold the written data and bits 31:17 still hold the written values.
- R8: While idle, the MDIO output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Frame word to send |
| reg_rdata | output | 32 | Frame register; bit 16 is the completion flag, bits 15:0 hold read data |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO data to drive |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO data from the bus |

## Verification
A bit counter that is off by one shifts the whole serial stream. It changes the pulse count, and the completion flag then appears 2*HALF_DIV clocks early or late, which the bench sees on the first transaction. A wrong slot decode shows up as the enable being released in the wrong bit time, or as read data shifted by one position in bits 15:0. A broken busy interlock lets an intruding write change the upper bits of the register, and this shows in the cycle after that write.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;

    localparam int FRAME_W  = 32;
    localparam int DONE_BIT = 16;
    localparam int DATA_W   = 16;
    // frame slots (counted from the first frame bit) where the bus turns round
    // and where read data starts
    localparam int TA_SLOT   = 14;
    localparam int DATA_SLOT = 16;
    localparam logic [1:0] OP_RD = 2'b10;

    function automatic logic op_is_read(input logic [FRAME_W-1:0] w);
        return w[29:28] == OP_RD;
    endfunction

endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } clk_st_t;

    clk_st_t s_d, s_q;
    logic    wrap;

    always_comb begin
        s_d       = s_q;
        wrap      = (s_q.cnt == CW'(HALF_DIV - 1));
        rise_tick = 1'b0;
        fall_tick = 1'b0;
        if (!run) begin
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
        end else if (wrap) begin
            s_d.cnt   = '0;
            s_d.mdc   = !s_q.mdc;
            rise_tick = !s_q.mdc;
            fall_tick = s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mdc = s_q.mdc;

endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
    import mdio_mgmt_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               rise_tick,
    input  logic               fall_tick,
    input  logic [FRAME_W-1:0] frame,
    input  logic               mdio_i,
    output logic               busy,
    output logic               done,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic [DATA_W-1:0]  cap
);
    localparam int NBITS = PRE_LEN + FRAME_W;
    localparam int BW    = $clog2(NBITS);

    typedef struct packed {
        logic              busy;
        logic [BW-1:0]     bit_cnt;
        logic [DATA_W-1:0] cap;
    } sh_st_t;

    sh_st_t s_d, s_q;
    logic   rd;
    logic   last;
    logic   in_pre;
    logic   released;
    logic   data_phase;
    int     slot;

    always_comb begin
        rd         = op_is_read(frame);
        slot       = int'(s_q.bit_cnt) - PRE_LEN;
        in_pre     = (slot < 0);
        released   = rd && !in_pre && (slot >= TA_SLOT);
        data_phase = rd && !in_pre && (slot >= DATA_SLOT);
        last       = (s_q.bit_cnt == BW'(NBITS - 1));

        if (!s_q.busy || in_pre) begin
            mdio_o = 1'b1;
        end else begin
            mdio_o = frame[5'(FRAME_W - 1 - slot)];
        end
        mdio_oe = s_q.busy && !released;

        s_d  = s_q;
        done = 1'b0;
        if (start) begin
            s_d.busy    = 1'b1;
            s_d.bit_cnt = '0;
            s_d.cap     = '0;
        end else if (s_q.busy) begin
            if (rise_tick && data_phase) begin
                s_d.cap = {s_q.cap[DATA_W-2:0], mdio_i};
            end
            if (fall_tick) begin
                if (last) begin
                    s_d.busy = 1'b0;
                    done     = 1'b1;
                end else begin
                    s_d.bit_cnt = s_q.bit_cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy = s_q.busy;
    assign cap  = s_q.cap;

endmodule

// File: rtl/mdio_frame_reg.sv
module mdio_frame_reg
    import mdio_mgmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [FRAME_W-1:0] wdata,
    input  logic               busy,
    input  logic               done,
    input  logic [DATA_W-1:0]  cap,
    output logic               start,
    output logic [FRAME_W-1:0] word
);
    typedef struct packed {
        logic [FRAME_W-1:0] word;
    } rg_st_t;

    rg_st_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        start = wr && !busy;
        if (start) begin
            s_d.word           = wdata;
            s_d.word[DONE_BIT] = 1'b0;
        end else if (done) begin
            s_d.word[DONE_BIT] = 1'b1;
            if (op_is_read(s_q.word)) begin
                s_d.word[DATA_W-1:0] = cap;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.word <= FRAME_W'(1) << DONE_BIT;
        end else begin
            s_q <= s_d;
        end
    end

    assign word = s_q.word;

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
    import mdio_mgmt_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int PRE_LEN  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic              busy_w;
    logic              done_w;
    logic              start_w;
    logic              rise_w;
    logic              fall_w;
    logic [DATA_W-1:0] cap_w;

    mdio_frame_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .busy  (busy_w),
        .done  (done_w),
        .cap   (cap_w),
        .start (start_w),
        .word  (reg_rdata)
    );

    mdio_clk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (busy_w),
        .mdc       (mdc),
        .rise_tick (rise_w),
        .fall_tick (fall_w)
    );

    mdio_shifter #(.PRE_LEN(PRE_LEN)) u_sh (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_w),
        .rise_tick (rise_w),
        .fall_tick (fall_w),
        .frame     (reg_rdata),
        .mdio_i    (mdio_i),
        .busy      (busy_w),
        .done      (done_w),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .cap       (cap_w)
    );

endmodule

// File: rtl/mdio_frame_master_chk.sv
module mdio_frame_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        reg_wr,
    input logic [31:0] reg_rdata,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe
);
    a_r2_mdc_low_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    a_r8_oe_off_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    a_r3_data_held_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> $stable(mdio_o));

    a_r4_flag_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !reg_rdata[16]);

    a_r4_flag_set_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> reg_rdata[16]);

    a_r5_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr) |=> $stable(reg_rdata[31:17]));

endmodule

bind mdio_frame_master mdio_frame_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy_w),
    .reg_wr    (reg_wr),
    .reg_rdata (reg_rdata),
    .mdc       (mdc),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe)
);

// File: tb/tb_mdio_frame_master.sv
module tb_mdio_frame_master;
    localparam int HALF  = 4;
    localparam int PRE   = 32;
    localparam int NB    = PRE + 32;
    localparam int TXLEN = 2 * HALF * NB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mdio_frame_master #(.HALF_DIV(HALF), .PRE_LEN(PRE)) dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    // PHY side model: record what is on the bus at each rising MDC edge
    logic        obs_o  [NB];
    logic        obs_oe [NB];
    int          rise_cnt = 0;
    logic [15:0] resp = '0;
    int          hi_run = 0;
    int          hi_bad = 0;

    function automatic logic resp_bit(int k, logic [15:0] r);
        if (k >= PRE + 16 && k < NB) return r[15 - (k - PRE - 16)];
        return 1'b1;
    endfunction

    always @(posedge mdc) begin
        if (rise_cnt < NB) begin
            obs_o[rise_cnt]  = mdio_o;
            obs_oe[rise_cnt] = mdio_oe;
        end
        rise_cnt++;
    end

    always @(negedge mdc) begin
        #1;
        mdio_i = resp_bit(rise_cnt, resp);
    end

    always @(negedge clk) begin
        if (mdc) hi_run++;
        else begin
            if (hi_run != 0 && hi_run != HALF) hi_bad++;
            hi_run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic run_txn(input logic [31:0] word, input logic [15:0] r,
                           input int intrude_at);
        int          elapsed;
        int          mis;
        logic        rd;
        logic [31:0] wx;
        logic [31:0] exp_word;
        logic        e_oe, e_o;
        rd       = (word[29:28] == 2'b10);
        wx       = word;
        wx[16]   = 1'b0;
        resp     = r;
        rise_cnt = 0;
        hi_bad   = 0;
        mdio_i   = 1'b1;
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = word;
        @(negedge clk);
        reg_wr = 1'b0;
        chk(reg_rdata == wx, "R4 flag cleared on accept", reg_rdata, wx);
        elapsed = 0;
        while (!reg_rdata[16] && elapsed < 4 * TXLEN) begin
            if (elapsed == intrude_at) begin
                reg_wr = 1'b1;
                reg_wdata = ~word;
            end else begin
                reg_wr = 1'b0;
            end
            @(negedge clk);
            elapsed++;
        end
        reg_wr = 1'b0;
        chk(elapsed == TXLEN, "R4 completion time", elapsed, TXLEN);
        exp_word = {word[31:17], 1'b1, rd ? r : word[15:0]};
        chk(reg_rdata == exp_word, rd ? "R6 read result" : "R7 write result",
            reg_rdata, exp_word);
        chk(rise_cnt == NB && hi_bad == 0, "R2 mdc pulses", rise_cnt, NB);
        mis = 0;
        for (int k = 0; k < NB; k++) begin
            e_oe = !(rd && k >= PRE + 14);
            e_o  = (k < PRE) ? 1'b1 : wx[31 - (k - PRE)];
            if (obs_oe[k] !== e_oe) mis++;
            if (e_oe && obs_o[k] !== e_o) mis++;
        end
        chk(mis == 0, rd ? "R3/R6 bus bits" : "R3/R7 bus bits", mis, 0);
        repeat (3) @(negedge clk);
        chk(mdc == 1'b0 && mdio_oe == 1'b0, "R8 idle bus", {mdc, mdio_oe}, 0);
        if (intrude_at >= 0)
            chk(reg_rdata == exp_word, "R5 busy write dropped", reg_rdata, exp_word);
    endtask

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] phy,
                                       input logic [4:0] ra, input logic [15:0] d);
        return {2'b01, op, phy, ra, 2'b10, d};
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(reg_rdata == 32'h0001_0000, "R1 reset value", reg_rdata, 32'h0001_0000);
        chk({mdc, mdio_oe, mdio_o} == 3'b001, "R1 reset bus", {mdc, mdio_oe, mdio_o}, 3'b001);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(reg_rdata == 32'h0001_0000, "R1 value after release", reg_rdata, 32'h0001_0000);
        chk(mdio_oe == 1'b0, "R8 idle before first write", mdio_oe, 0);

        // directed corners
        run_txn(mk(2'b01, 5'd1, 5'd0, 16'h1000), 16'h0000, -1);
        run_txn(mk(2'b10, 5'd31, 5'd31, 16'h0000), 16'hA5C3, -1);
        run_txn(mk(2'b10, 5'd0, 5'd1, 16'h0000), 16'hFFFF, -1);
        run_txn(mk(2'b00, 5'd7, 5'd9, 16'h8001), 16'h1234, -1);
        run_txn(mk(2'b01, 5'd2, 5'd3, 16'h0F0F) | 32'h0001_0000, 16'h0, -1);
        run_txn(mk(2'b10, 5'd4, 5'd5, 16'h0), 16'h0001, 10);
        run_txn(mk(2'b01, 5'd6, 5'd7, 16'hBEEF), 16'h0, TXLEN - 1);

        // random mix
        for (int n = 0; n < 20; n++) begin
            logic [1:0] op;
            int intr;
            op   = ($urandom % 2) ? 2'b10 : 2'b01;
            intr = ($urandom % 3 == 0) ? int'($urandom % TXLEN) : -1;
            run_txn(mk(op, 5'($urandom), 5'($urandom), 16'($urandom)),
                    16'($urandom), intr);
        end

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog expired act=%0d exp=0", 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule